// File: doc/BRIEF.md
# Addressed Serial Control Register Bank

This block receives 24-bit configuration words over a three-wire serial port (serial clock, serial data, latch strobe) and stores each word in one of eight control registers. The target register is named by the low three bits of the word itself, so one port reaches all eight registers and no separate address line is needed. All three serial wires are treated as asynchronous. They are brought into the system clock domain, and rising edges are detected there. Shifting and latching both act on those detected edges.

One register also carries a 4-bit select field for a single output pin. The select steers one of several sources onto the pin: lock detect, the two divider outputs, a timer output, an echo of the serial shift chain, or a constant high or low. The pin can also be released to high impedance. A write to register 0 produces a one-cycle pulse that other logic can use, for example to restart lock detection after a new channel is programmed.

Top module: `ctrl_serial_bank`

## Requirements
- R1: Serial data is sampled on each rising serial-clock edge and shifted in most significant bit first. When the latch strobe rises, the word that is transferred is the last 24 bits shifted, even if more than 24 bits were sent.
- R2: On a latch-strobe rising edge, all 24 bits of the shifted word are written into the register whose index equals word bits [2:0] (000 is register 0, 111 is register 7). On `regs_o`, register k occupies bits [24k+23:24k].
- R3: Registers that are not addressed keep their values. Shifting bits without a latch-strobe rise changes no register.
- R4: `chan_prog` is high for exactly one clock cycle for each write to register 0, and it stays low for writes to any other register.
- R5: The output select is bits [6:3] of register 6. Code 1 drives the pin high. Code 2 drives it low. Code 3 passes `lock_det`, code 4 passes `rdiv_out`, code 5 passes `ndiv_out` and code 6 passes `timer_out`. For all of these codes `mux_oe` is 1.
- R6: Code 0 and codes 8 to 15 select high impedance, with `mux_oe` at 0 and `mux_out` at 0.
- R7: Code 7 echoes bit 23 of the serial shift chain (the oldest bit held), with `mux_oe` at 1. The echo follows further shifting even when no latch-strobe rise occurs.
- R8: With two synchroniser stages, a register write becomes visible on `regs_o` after the third rising system-clock edge that follows the latch-strobe rise. `chan_prog` is high in the cycle after that same edge.
- R9: While reset is held (synchronous, active low), all registers clear to zero and `chan_prog` is low, which leaves the pin in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_latch | input | 1 | Latch strobe, asynchronous; rising edge commits the word |
| lock_det | input | 1 | Lock-detect source for the output pin |
| rdiv_out | input | 1 | Reference-divider source for the output pin |
| ndiv_out | input | 1 | Feedback-divider source for the output pin |
| timer_out | input | 1 | Timer source for the output pin |
| regs_o | output | 192 | All eight control registers, register k at [24k+23:24k] |
| chan_prog | output | 1 | One-cycle pulse after a write to register 0 |
| mux_out | output | 1 | Output pin value |
| mux_oe | output | 1 | Output pin enable; 0 means high impedance |

## Verification
A latch-strobe rise reaches `regs_o` after the third rising clock edge, and `chan_prog` is high for the one cycle after that edge. The timing check raises the strobe on a falling clock edge. It then samples half a cycle past the second and the third rising edges, and expects the old value at the second and the new value at the third. All other register checks wait several idle cycles after the strobe falls, so they cannot depend on that latency. The output pin is combinational from the stored select and the source inputs, so those checks change the sources and sample one full clock later.

// File: rtl/ctrlbank_pkg.sv
package ctrlbank_pkg;

    localparam int unsigned FRAME_W_DEF  = 24;
    localparam int unsigned NUM_REGS_DEF = 8;
    localparam int unsigned SYNC_DEF     = 2;
    localparam int unsigned SEL_W        = 4;

    typedef enum logic [SEL_W-1:0] {
        MX_HIZ   = 4'd0,
        MX_HIGH  = 4'd1,
        MX_LOW   = 4'd2,
        MX_LOCK  = 4'd3,
        MX_RDIV  = 4'd4,
        MX_NDIV  = 4'd5,
        MX_TIMER = 4'd6,
        MX_ECHO  = 4'd7
    } mux_code_e;

endpackage

// File: rtl/ctrlbank_sync.sv
module ctrlbank_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned NE     = 2,
    parameter int unsigned NL     = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] edge_raw,
    input  logic [NL-1:0] lvl_raw,
    output logic [NE-1:0] edge_rise,
    output logic [NL-1:0] lvl_sync
);

    typedef struct packed {
        logic [STAGES-1:0][NE-1:0] ep;
        logic [STAGES-1:0][NL-1:0] lp;
        logic [NE-1:0]             eprev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.ep[0] = edge_raw;
        s_d.lp[0] = lvl_raw;
        for (int i = 1; i < int'(STAGES); i++) begin
            s_d.ep[i] = s_q.ep[i-1];
            s_d.lp[i] = s_q.lp[i-1];
        end
        s_d.eprev = s_q.ep[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign edge_rise = s_q.ep[STAGES-1] & ~s_q.eprev;
    assign lvl_sync  = s_q.lp[STAGES-1];

endmodule

// File: rtl/ctrlbank_shifter.sv
module ctrlbank_shifter #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);

    typedef struct packed {
        logic [W-1:0] sr;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_en) begin
            s_d.sr = {s_q.sr[W-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word = s_q.sr;

endmodule

// File: rtl/ctrlbank_regfile.sv
module ctrlbank_regfile #(
    parameter int unsigned W = 24,
    parameter int unsigned N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [W-1:0]   word,
    output logic [N*W-1:0] regs_flat,
    output logic           r0_wr
);

    localparam int unsigned AW = $clog2(N);

    logic [N-1:0] hit;

    for (genvar g = 0; g < int'(N); g++) begin : g_dec
        assign hit[g] = we && (word[AW-1:0] == AW'(g));
    end

    typedef struct packed {
        logic [N-1:0][W-1:0] regs;
        logic                r0_pulse;
    } rf_t;

    rf_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.r0_pulse = hit[0];
        for (int k = 0; k < int'(N); k++) begin
            if (hit[k]) s_d.regs[k] = word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign regs_flat = s_q.regs;
    assign r0_wr     = s_q.r0_pulse;

endmodule

// File: rtl/ctrlbank_outmux.sv
module ctrlbank_outmux
    import ctrlbank_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             lock,
    input  logic             rdiv,
    input  logic             ndiv,
    input  logic             timer,
    input  logic             echo,
    output logic             out,
    output logic             oe
);

    typedef struct packed {
        logic out;
        logic oe;
    } pin_t;

    pin_t p_d;

    always_comb begin
        p_d.out = 1'b0;
        p_d.oe  = 1'b1;
        case (mux_code_e'(sel))
            MX_HIGH:  p_d.out = 1'b1;
            MX_LOW:   p_d.out = 1'b0;
            MX_LOCK:  p_d.out = lock;
            MX_RDIV:  p_d.out = rdiv;
            MX_NDIV:  p_d.out = ndiv;
            MX_TIMER: p_d.out = timer;
            MX_ECHO:  p_d.out = echo;
            default:  p_d.oe  = 1'b0;
        endcase
    end

    assign out = p_d.out;
    assign oe  = p_d.oe;

endmodule

// File: rtl/ctrl_serial_bank.sv
module ctrl_serial_bank
    import ctrlbank_pkg::*;
#(
    parameter int unsigned FRAME_W     = FRAME_W_DEF,
    parameter int unsigned NUM_REGS    = NUM_REGS_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF,
    parameter int unsigned MUX_REG     = 6,
    parameter int unsigned MUX_LSB     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_clk,
    input  logic                        ser_data,
    input  logic                        ser_latch,
    input  logic                        lock_det,
    input  logic                        rdiv_out,
    input  logic                        ndiv_out,
    input  logic                        timer_out,
    output logic [FRAME_W*NUM_REGS-1:0] regs_o,
    output logic                        chan_prog,
    output logic                        mux_out,
    output logic                        mux_oe
);

    localparam int unsigned SEL_POS = MUX_REG * FRAME_W + MUX_LSB;

    logic [1:0]         rises;
    logic               sclk_rise;
    logic               le_rise;
    logic               sdata_s;
    logic [FRAME_W-1:0] shift_word;
    logic [SEL_W-1:0]   sel;

    ctrlbank_sync #(
        .STAGES (SYNC_STAGES),
        .NE     (2),
        .NL     (1)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_raw  ({ser_latch, ser_clk}),
        .lvl_raw   (ser_data),
        .edge_rise (rises),
        .lvl_sync  (sdata_s)
    );

    assign sclk_rise = rises[0];
    assign le_rise   = rises[1];

    ctrlbank_shifter #(
        .W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .din      (sdata_s),
        .word     (shift_word)
    );

    ctrlbank_regfile #(
        .W (FRAME_W),
        .N (NUM_REGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (le_rise),
        .word      (shift_word),
        .regs_flat (regs_o),
        .r0_wr     (chan_prog)
    );

    assign sel = regs_o[SEL_POS +: SEL_W];

    ctrlbank_outmux u_mux (
        .sel   (sel),
        .lock  (lock_det),
        .rdiv  (rdiv_out),
        .ndiv  (ndiv_out),
        .timer (timer_out),
        .echo  (shift_word[FRAME_W-1]),
        .out   (mux_out),
        .oe    (mux_oe)
    );

endmodule

// File: rtl/ctrlbank_chk.sv
module ctrlbank_chk #(
    parameter int unsigned W       = 24,
    parameter int unsigned N       = 8,
    parameter int unsigned MUX_REG = 6,
    parameter int unsigned MUX_LSB = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           le_rise,
    input logic [W-1:0]   shift_word,
    input logic [N*W-1:0] regs_flat,
    input logic           chan_prog,
    input logic           mux_out,
    input logic           mux_oe
);

    localparam int unsigned AW = $clog2(N);

    logic [3:0] sel_seen;
    assign sel_seen = regs_flat[MUX_REG*W+MUX_LSB +: 4];

    p_write_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> (regs_flat[int'($past(shift_word[AW-1:0]))*W +: W] == $past(shift_word)));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(regs_flat));

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_prog |=> !chan_prog);

    p_pulse_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_prog |-> ($past(le_rise) && ($past(shift_word[AW-1:0]) == '0)));

    p_const_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_seen == 4'd1) |-> (mux_out && mux_oe));

    p_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_seen == 4'd0) || sel_seen[3]) |-> (!mux_oe && !mux_out));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> ((regs_flat == '0) && !chan_prog));

endmodule

bind ctrl_serial_bank ctrlbank_chk #(
    .W       (FRAME_W),
    .N       (NUM_REGS),
    .MUX_REG (MUX_REG),
    .MUX_LSB (MUX_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .le_rise    (le_rise),
    .shift_word (shift_word),
    .regs_flat  (regs_o),
    .chan_prog  (chan_prog),
    .mux_out    (mux_out),
    .mux_oe     (mux_oe)
);

// File: tb/ctrl_serial_bank_tb.sv
module ctrl_serial_bank_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_data = 1'b0;
    logic         ser_latch = 1'b0;
    logic         lock_det = 1'b0;
    logic         rdiv_out = 1'b0;
    logic         ndiv_out = 1'b0;
    logic         timer_out = 1'b0;
    logic [191:0] regs_o;
    logic         chan_prog;
    logic         mux_out;
    logic         mux_oe;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [23:0] exp_r [8];

    always #5 clk = ~clk;

    ctrl_serial_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .lock_det  (lock_det),
        .rdiv_out  (rdiv_out),
        .ndiv_out  (ndiv_out),
        .timer_out (timer_out),
        .regs_o    (regs_o),
        .chan_prog (chan_prog),
        .mux_out   (mux_out),
        .mux_oe    (mux_oe)
    );

    always @(posedge clk) if (chan_prog === 1'b1) pulses <= pulses + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < 8; k++)
            chk(regs_o[k*24 +: 24] === exp_r[k], req, $sformatf("reg %0d", k),
                {8'h0, regs_o[k*24 +: 24]}, {8'h0, exp_r[k]});
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_clk  = 1'b0;
            ser_data = w[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
        end
        ser_clk = 1'b0;
    endtask

    task automatic latch();
        @(negedge clk);
        ser_latch = 1'b1;
        repeat (4) @(negedge clk);
        ser_latch = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_word(input logic [23:0] w);
        send_bits({8'h0, w}, 24);
        latch();
        exp_r[w[2:0]] = w;
    endtask

    function automatic logic [1:0] exp_pin(input int code, input logic lk, input logic rd,
                                           input logic nd, input logic tm, input logic ec);
        case (code)
            1: return 2'b11;
            2: return 2'b10;
            3: return {1'b1, lk};
            4: return {1'b1, rd};
            5: return {1'b1, nd};
            6: return {1'b1, tm};
            7: return {1'b1, ec};
            default: return 2'b00;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p0;
        logic [23:0] w;
        for (int k = 0; k < 8; k++) exp_r[k] = '0;
        repeat (5) @(negedge clk);
        check_all("R9");
        chk(mux_oe === 1'b0 && mux_out === 1'b0, "R6", "pin after reset", {30'h0, mux_oe, mux_out}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2 R3 R4: one write to every address
        for (int a = 0; a < 8; a++) begin
            p0 = pulses;
            w  = {21'(32'h0B5A3 * (a + 1)), 3'(a)};
            write_word(w);
            check_all("R2");
            chk((pulses - p0) == (a == 0 ? 1 : 0), "R4", $sformatf("pulses for addr %0d", a),
                32'(pulses - p0), (a == 0) ? 32'd1 : 32'd0);
        end

        // R3: shifting without a latch changes nothing
        p0 = pulses;
        send_bits(32'h00FFFFF8, 24);
        repeat (6) @(negedge clk);
        check_all("R3");
        chk(pulses == p0, "R3", "pulses without latch", 32'(pulses - p0), 32'd0);

        // R1: oversized frame keeps only the last 24 bits
        send_bits(32'h2A, 6);
        send_bits(32'h00C3E59B, 24);
        latch();
        exp_r[3] = 24'hC3E59B;
        check_all("R1");

        // R8: exact latency of a write to register 0
        send_bits(32'h00ABCDE0, 24);
        @(negedge clk);
        ser_latch = 1'b1;
        @(posedge clk); @(posedge clk); #5;
        chk(regs_o[23:0] === exp_r[0], "R8", "reg0 before third edge", {8'h0, regs_o[23:0]}, {8'h0, exp_r[0]});
        chk(chan_prog === 1'b0, "R8", "pulse before third edge", {31'h0, chan_prog}, 32'h0);
        @(posedge clk); #5;
        chk(regs_o[23:0] === 24'hABCDE0, "R8", "reg0 after third edge", {8'h0, regs_o[23:0]}, 32'hABCDE0);
        chk(chan_prog === 1'b1, "R8", "pulse after third edge", {31'h0, chan_prog}, 32'h1);
        @(posedge clk); #5;
        chk(chan_prog === 1'b0, "R4", "pulse width", {31'h0, chan_prog}, 32'h0);
        exp_r[0] = 24'hABCDE0;
        ser_latch = 1'b0;
        repeat (4) @(negedge clk);

        // R5 R6 R7: every select code against every source pattern
        for (int code = 0; code < 16; code++) begin
            write_word({1'b0, 16'h0, 4'(code), 3'd6});
            for (int v = 0; v < 16; v++) begin
                logic [1:0] e;
                @(negedge clk);
                {lock_det, rdiv_out, ndiv_out, timer_out} = 4'(v);
                @(negedge clk);
                e = exp_pin(code, lock_det, rdiv_out, ndiv_out, timer_out, 1'b0);
                chk({mux_oe, mux_out} === e,
                    (code == 0 || code > 7) ? "R6" : (code == 7 ? "R7" : "R5"),
                    $sformatf("code %0d sources %0d", code, v),
                    {30'h0, mux_oe, mux_out}, {30'h0, e});
            end
        end
        check_all("R3");

        // R7: echo follows the oldest shift-chain bit
        write_word({1'b1, 16'h0, 4'd7, 3'd6});
        chk({mux_oe, mux_out} === 2'b11, "R7", "echo high", {30'h0, mux_oe, mux_out}, 32'h3);
        send_bits(32'h0, 1);
        repeat (4) @(negedge clk);
        chk({mux_oe, mux_out} === 2'b10, "R7", "echo after one shift", {30'h0, mux_oe, mux_out}, 32'h2);
        check_all("R7");

        // R9: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) exp_r[k] = '0;
        check_all("R9");
        chk(mux_oe === 1'b0 && chan_prog === 1'b0, "R9", "pin and pulse in reset",
            {30'h0, mux_oe, chan_prog}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule